// File: doc/BRIEF.md
# Fuse Array Read Controller

This block gives a host read access to a small one-time-programmable fuse array through a simple register bus. The bus has an address, a write strobe, write data and combinational read data. The fuse contents sit in an internal constant table that is computed at elaboration. There is no programming path.

A read takes several steps. Software first powers the array up and sets the auto-read enable. It then loads a word index by writing the index together with a one-shot address-load bit. Next it writes a one-shot start bit. It polls a busy flag until the flag drops, and finally fetches the result from a data register.

The busy period stands in for the fuse sensing delay and lasts a fixed, parameterised number of cycles. The word size is 1 or 4 bytes, chosen by parameter. The word index is scaled by the word size to form the byte offset into the 512-byte array. Bits that belong to the programming side of the interface are kept so that they read back, but they drive nothing.

Top module: `fuse_read_ctrl`

## Requirements
- R1: After reset, the control register at offset 0x04 reads 0x0800_0000 (power-down bit 27 set, all other bits 0). The data register at 0x08 reads 0, the auxiliary register at 0x10 reads 0, and busy (bit 26 of 0x04) is 0.
- R2: Register 0x04 keeps and returns power-down (bit 27), read enable (bit 24), program byte (bits 23:16), program enable (bit 12) and address field (bits 10:0). Bits 25, 14, 13 and 11, and all unlisted bits, read 0. Register 0x10 keeps only bit 10. Writes to 0x08 are ignored. Unmapped offsets read 0.
- R3: The word index used by later reads changes only on a write to 0x04 with bit 11 set, which loads it from bits 10:0 of that write. A write that changes the address field with bit 11 clear leaves the index used for reads unchanged.
- R4: A write to 0x04 is a start when it has bit 25 = 1, bit 27 = 0 and bit 24 = 1 (all taken from that same write) and no read is running. Busy (bit 26 of 0x04) reads 1 in the cycle right after that write.
- R5: A write with bit 25 = 1 while bit 27 = 1 or bit 24 = 0 in that write starts nothing: busy stays 0 and the data register keeps its value.
- R6: Busy stays 1 for exactly BUSY_CYCLES cycles (default 8). The data register loads the result on the same edge where busy clears, and it changes at no other time.
- R7: The result holds the fuse bytes at byte offsets index*WORD_BYTES + j, with byte j in bits 8j+7:8j (little-endian). The byte at offset b is ((b*37 + 11) XOR (b >> 3)) mod 256.
- R8: Any byte whose offset is at or beyond the array size (512) reads as 0, so a word index past the array returns all zeros.
- R9: A start written while busy is 1 is ignored: the running read keeps its length and its word index.
- R10: When one write sets both bit 11 and bit 25, the read uses the word index carried in that same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| reg_addr | input | BUS_AW | Register byte offset |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The bench polls busy once per cycle straight after a start. A design that sets busy one cycle late shows a 0 on that first poll. A sensing window that is off by one gives the wrong count. A second start in the middle of a read must leave only the remaining cycles of the first read; a design that restarts the timer shows a longer window. Reads at the last valid word and just past it show whether the array bound is handled: an unguarded table returns nonzero data past the end. Writing the address field without the load bit shows whether a design latches the index too eagerly. Starts issued while powered down or with read enable clear show whether the power-down and enable gating works, because a wrongly gated design would overwrite the data register.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_AUX  = 8'h10;

  localparam int B_PWRDN  = 27;
  localparam int B_BUSY   = 26;
  localparam int B_GO     = 25;
  localparam int B_RDEN   = 24;
  localparam int B_PBYTE  = 16;
  localparam int B_PGMEN  = 12;
  localparam int B_LOAD   = 11;
  localparam int B_ENC    = 10;
  localparam int IDX_W    = 11;

  // Fuse content, defined arithmetically so no table is stored in source.
  function automatic logic [7:0] fuse_byte(input logic [31:0] off);
    logic [31:0] mix;
    mix = off * 32'd37 + 32'd11;
    return mix[7:0] ^ off[10:3];
  endfunction

endpackage

// File: rtl/fuse_csr.sv
module fuse_csr
  import fuse_rd_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic [31:0]       result,
  output logic [31:0]       reg_rdata,
  output logic              go,
  output logic [IDX_W-1:0]  go_idx,
  output logic [IDX_W-1:0]  lat_idx
);

  logic              sel_ctrl, sel_aux, sel_data;
  logic              wr_ctrl, wr_aux;
  logic              pwrdn_q, pwrdn_d;
  logic              rden_q, rden_d;
  logic              pgmen_q, pgmen_d;
  logic              enc_q, enc_d;
  logic [7:0]        pbyte_q, pbyte_d;
  logic [IDX_W-1:0]  fld_q, fld_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              ctrl_en, aux_en, idx_en;
  logic [31:0]       unused_wbits;

  assign sel_ctrl = (reg_addr == BUS_AW'(OFS_CTRL));
  assign sel_aux  = (reg_addr == BUS_AW'(OFS_AUX));
  assign sel_data = (reg_addr == BUS_AW'(OFS_DATA));
  assign wr_ctrl  = reg_we && sel_ctrl;
  assign wr_aux   = reg_we && sel_aux;

  // Next-state for stored fields
  always_comb begin
    pwrdn_d = reg_wdata[B_PWRDN];
    rden_d  = reg_wdata[B_RDEN];
    pgmen_d = reg_wdata[B_PGMEN];
    pbyte_d = reg_wdata[B_PBYTE +: 8];
    fld_d   = reg_wdata[IDX_W-1:0];
    enc_d   = reg_wdata[B_ENC];
    idx_d   = reg_wdata[IDX_W-1:0];
    ctrl_en = wr_ctrl;
    aux_en  = wr_aux;
    idx_en  = wr_ctrl && reg_wdata[B_LOAD];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrdn_q <= 1'b1;
      rden_q  <= 1'b0;
      pgmen_q <= 1'b0;
      pbyte_q <= '0;
      fld_q   <= '0;
    end else if (ctrl_en) begin
      pwrdn_q <= pwrdn_d;
      rden_q  <= rden_d;
      pgmen_q <= pgmen_d;
      pbyte_q <= pbyte_d;
      fld_q   <= fld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q <= 1'b0;
    end else if (aux_en) begin
      enc_q <= enc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  // Start qualification uses the fields carried by the same write
  assign go      = wr_ctrl && reg_wdata[B_GO] && !reg_wdata[B_PWRDN]
                   && reg_wdata[B_RDEN] && !busy;
  assign go_idx  = reg_wdata[B_LOAD] ? reg_wdata[IDX_W-1:0] : idx_q;
  assign lat_idx = idx_q;

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata = {4'b0, pwrdn_q, busy, 1'b0, rden_q, pbyte_q,
                   3'b000, pgmen_q, 1'b0, fld_q};
    end else if (sel_aux) begin
      reg_rdata[B_ENC] = enc_q;
    end else if (sel_data) begin
      reg_rdata = result;
    end
  end

  assign unused_wbits = {reg_wdata[31:28], reg_wdata[26:25], reg_wdata[15:13],
                         reg_wdata[B_LOAD], 21'b0};

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_rd_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [IDX_W-1:0] go_idx,
  input  logic [31:0]      rom_word,
  output logic [IDX_W-1:0] rom_idx,
  output logic             busy,
  output logic [31:0]      result
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [31:0]      res_q, res_d;
  logic             upd_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    res_d  = res_q;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        res_d  = rom_word;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (go) begin
      busy_d = 1'b1;
      cnt_d  = LAST;
      idx_d  = go_idx;
    end
  end

  assign upd_en = busy_q || go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      res_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      res_q  <= res_d;
    end
  end

  assign rom_idx = idx_q;
  assign busy    = busy_q;
  assign result  = res_q;

endmodule

// File: rtl/fuse_rom.sv
module fuse_rom
  import fuse_rd_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      word
);

  for (genvar j = 0; j < 4; j++) begin : g_lane
    if (j < WORD_BYTES) begin : g_used
      logic [31:0] off;
      assign off = 32'(idx) * WORD_BYTES + j;
      assign word[8*j +: 8] = (off < ARRAY_BYTES) ? fuse_byte(off) : 8'h00;
    end else begin : g_pad
      assign word[8*j +: 8] = 8'h00;
    end
  end

endmodule

// File: rtl/fuse_read_ctrl.sv
module fuse_read_ctrl
  import fuse_rd_pkg::*;
#(
  parameter int WORD_BYTES  = 4,
  parameter int ARRAY_BYTES = 512,
  parameter int BUSY_CYCLES = 8,
  parameter int BUS_AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             go;
  logic [IDX_W-1:0] go_idx, lat_idx, rom_idx;
  logic             seq_busy;
  logic [31:0]      seq_result, rom_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  fuse_csr #(.BUS_AW(BUS_AW)) i_csr (
    .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .busy(seq_busy), .result(seq_result),
    .reg_rdata(reg_rdata), .go(go), .go_idx(go_idx), .lat_idx(lat_idx)
  );

  fuse_seq #(.BUSY_CYCLES(BUSY_CYCLES)) i_seq (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .go_idx(go_idx),
    .rom_word(rom_word), .rom_idx(rom_idx), .busy(seq_busy), .result(seq_result)
  );

  fuse_rom #(.WORD_BYTES(WORD_BYTES), .ARRAY_BYTES(ARRAY_BYTES)) i_rom (
    .idx(rom_idx), .word(rom_word)
  );

endmodule

// File: rtl/fuse_read_ctrl_chk.sv
module fuse_read_ctrl_chk
  import fuse_rd_pkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter int BUS_AW      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              busy,
  input logic [31:0]       result,
  input logic [IDX_W-1:0]  lat_idx
);

  logic wr_ctrl;
  int   busy_len;

  assign wr_ctrl = reg_we && (reg_addr == BUS_AW'(OFS_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[B_GO] && !reg_wdata[B_PWRDN] && reg_wdata[B_RDEN] && !busy) |=> busy); // R4

  AST_BUSY_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == BUS_AW'(OFS_CTRL)) |-> (reg_rdata[B_BUSY] == busy)); // R4

  AST_GATED_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[B_GO] && (reg_wdata[B_PWRDN] || !reg_wdata[B_RDEN]) && !busy)
      |=> (!busy && $stable(result))); // R5

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == BUSY_CYCLES)); // R6

  AST_RESULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy)); // R6

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ctrl && reg_wdata[B_LOAD]) |=> $stable(lat_idx)); // R3

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata[B_LOAD]) |=> (lat_idx == $past(reg_wdata[IDX_W-1:0]))); // R3

  AST_PULSE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == BUS_AW'(OFS_CTRL)) |-> (!reg_rdata[B_GO] && !reg_rdata[B_LOAD]
                                          && !reg_rdata[13] && !reg_rdata[14])); // R2

endmodule

bind fuse_read_ctrl fuse_read_ctrl_chk #(
  .BUSY_CYCLES(BUSY_CYCLES), .BUS_AW(BUS_AW)
) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(seq_busy),
  .result(seq_result), .lat_idx(lat_idx)
);

// File: tb/test_fuse_read_ctrl.sv
`timescale 1ns/1ps
module test_fuse_read_ctrl;

  localparam int WB   = 4;
  localparam int BUSY = 8;
  localparam logic [7:0] A_CTRL = 8'h04, A_DATA = 8'h08, A_AUX = 8'h10;
  localparam logic [31:0] PWRDN = 32'h0800_0000, RDEN = 32'h0100_0000,
                          GO = 32'h0200_0000, LOAD = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mon_val;
  event        mon_ev;

  always #10 clk = ~clk;

  fuse_read_ctrl #(.WORD_BYTES(WB), .BUSY_CYCLES(BUSY)) i_fuse_read_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int b);
    int lo, hi;
    lo = (b * 37 + 11) % 256;
    hi = (b / 8) % 256;
    return 8'(lo ^ hi);
  endfunction

  function automatic logic [31:0] word_at(input int idx);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < WB; j++) begin
      if (idx * WB + j < 512) w[8*j +: 8] = byte_at(idx * WB + j);
    end
    return w;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic poll(output int n, output logic first);
    logic [31:0] v;
    n = 0; first = 1'b0;
    for (int k = 0; k < 200; k++) begin
      rd(A_CTRL, v);
      if (k == 0) first = v[26];
      if (!v[26]) break;
      n++;
    end
  endtask

  // Driver side: push expectation, then hand the fetched word to the monitor
  task automatic collect(input string req, input logic [31:0] exp);
    logic [31:0] v;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    rd(A_DATA, v);
    mon_val = v;
    -> mon_ev;
  endtask

  task automatic fetch(input string req, input int idx, input bit fused);
    int n; logic first;
    if (fused) begin
      wr(A_CTRL, RDEN | LOAD | GO | 32'(idx));
    end else begin
      wr(A_CTRL, RDEN | LOAD | 32'(idx));
      wr(A_CTRL, RDEN | GO | 32'(idx));
    end
    poll(n, first);
    chk({req, " R4 busy on first poll"}, 32'(first), 32'd1);
    chk({req, " R6 busy cycles"}, 32'(n), 32'(BUSY));
    collect(req, word_at(idx));
  endtask

  initial begin : monitor
    forever begin
      @(mon_ev);
      if (exp_q.size() == 0) begin
        chk("scoreboard underflow", mon_val, 32'hxxxx_xxxx);
      end else begin
        chk(tag_q.pop_front(), mon_val, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin : stim
    logic [31:0] v;
    int n; logic first;
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0800_0000);
    rd(A_DATA, v); chk("R1 data after reset", v, 32'h0);
    rd(A_AUX, v);  chk("R1 aux after reset", v, 32'h0);

    // R2 readback of stored fields, pulse bits read zero
    wr(A_CTRL, PWRDN | RDEN | 32'h00A5_1000 | 32'h0000_6000 | 32'h123);
    rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h09A5_1123);
    wr(A_AUX, 32'hFFFF_FFFF);
    rd(A_AUX, v); chk("R2 aux keeps bit 10 only", v, 32'h0000_0400);
    wr(A_AUX, 32'h0);
    wr(A_DATA, 32'hDEAD_BEEF);
    rd(A_DATA, v); chk("R2 data ignores writes", v, 32'h0);
    rd(8'h0C, v); chk("R2 unmapped reads zero", v, 32'h0);

    // R7 normal reads, split and fused
    fetch("R7 idx 5", 5, 0);
    fetch("R7 idx 0", 0, 0);
    fetch("R10 load and go in one write", 64, 1);

    // R5 gated starts leave busy low and data unchanged
    wr(A_CTRL, PWRDN | RDEN | GO | LOAD | 32'd7);
    rd(A_CTRL, v); chk("R5 powered down: busy", 32'(v[26]), 32'd0);
    rd(A_DATA, v); chk("R5 powered down: data kept", v, word_at(64));
    wr(A_CTRL, GO | LOAD | 32'd7);
    rd(A_CTRL, v); chk("R5 read disabled: busy", 32'(v[26]), 32'd0);
    rd(A_DATA, v); chk("R5 read disabled: data kept", v, word_at(64));

    // R3 address field without load bit does not move the index
    fetch("R3 set idx 5", 5, 0);
    wr(A_CTRL, RDEN | 32'd9);
    wr(A_CTRL, RDEN | GO | 32'd9);
    poll(n, first);
    chk("R3 busy cycles", 32'(n), 32'(BUSY));
    collect("R3 index unchanged", word_at(5));

    // R8 array edge
    fetch("R8 last word", 127, 0);
    fetch("R8 first word past end", 128, 0);
    fetch("R7 restore nonzero", 33, 1);
    fetch("R8 highest index", 2047, 0);

    // R9 start during busy
    wr(A_CTRL, RDEN | LOAD | GO | 32'd21);
    rd(A_CTRL, v); rd(A_CTRL, v);
    wr(A_CTRL, RDEN | LOAD | GO | 32'd40);
    poll(n, first);
    chk("R9 remaining busy cycles", 32'(n), 32'(BUSY - 3));
    collect("R9 first read data", word_at(21));

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule